// File: doc/BRIEF.md
# Iterative Arithmetic Left Shifter

This unit shifts a signed value left, one bit position per clock, at one of three operand widths: 8, 16 or 32 bits. A caller presents the operand, a width select and a shift amount together with a one-cycle `start`. The shift amount comes either from a 5-bit immediate field or from a 32-bit register value, of which only the low five bits are used. When the work is complete the unit pulses `done` and presents the result and four flags: carry, overflow, negative and zero. The result and the flags hold until the next operation completes.

Overflow is sticky for the whole operation. It is set if the sign bit of the selected width flips at any single step, and it stays set even when later steps bring the original sign back. Carry receives each bit leaving the top of the selected width, so it ends up holding the last bit shifted out. Operand bits above the selected width take no part in the operation, and the unit drives them to zero on the result.

Control is a three-state machine:
- `ST_IDLE` waits for `start`. Transition *launch*: `start` with a non-zero amount, which goes to `ST_SHIFT`. Transition *bypass*: `start` with a zero amount, which goes straight to `ST_FINISH`.
- `ST_SHIFT` performs one step per clock. Transition *last_step*: it leaves for `ST_FINISH` on the step where the remaining amount is 1, and otherwise stays in `ST_SHIFT`.
- `ST_FINISH` raises `done` for one cycle. Transition *retire*: it always returns to `ST_IDLE`.

Top module: `asl_iter_unit`

## Requirements
- R1: For an amount N from 1 to 31, the result equals the operand, restricted to the selected width, shifted left by N positions. The vacated low bits are filled with zeros.
- R2: After a non-zero shift, `flag_c` holds the last bit that left the top bit position of the selected width.
- R3: With an amount of 0, the result equals the operand restricted to the selected width. `flag_c` keeps its previous value, `flag_v` is 0, and `flag_n` and `flag_z` describe the unchanged value.
- R4: When `cnt_from_reg` is 1, the amount is `cnt_reg[4:0]` and the upper bits are ignored, so 0x25 shifts by 5 and 0x20 shifts by 0. When `cnt_from_reg` is 0, the amount is `cnt_imm`.
- R5: The `size_sel` encoding is 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. The sign bit is the top bit of the selected width. Operand bits above the width are ignored, and the corresponding result bits are 0.
- R6: `flag_v` is 1 if the sign bit changes at any step, including the case where a later step restores the original sign.
- R7: `flag_v` is 0 after an operation in which the sign bit never changed, even if the previous operation set it.
- R8: `flag_n` equals the top bit of the result at the selected width. `flag_z` is 1 exactly when the result bits within the width are all zero.
- R9: If `start` is sampled at rising edge k with amount N, `done` is high during the cycle after edge k+N, and only for that one cycle.
- R10: While `busy` is high, `start` is ignored. No extra `done` occurs and the running result is unaffected.
- R11: Reset clears `busy`, `done`, the result and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| operand | input | 32 | Value to shift |
| size_sel | input | 2 | Width select: 00 = 8, 01 = 16, 1x = 32 |
| cnt_from_reg | input | 1 | 1 = use the register amount, 0 = use the immediate |
| cnt_imm | input | 5 | Immediate shift amount |
| cnt_reg | input | 32 | Register shift amount (low 5 bits used) |
| result | output | 32 | Shifted value; bits above the width are 0 |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Sticky overflow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
The hardest case to reach is an overflow whose sign flip is later undone: the final value has the same sign as the input, yet `flag_v` must be 1. The stimulus produces it with an 8-bit operand of 0x40 shifted by 2 and a 32-bit operand of 0x40000000 shifted by 2. In both, the sign goes 0 to 1 to 0. A clean shift follows directly to show that the flag clears. Ignoring a start while busy is driven by pulsing `start` with a different operand and a zero amount in the middle of a long shift. The monitor's queue would then expose any extra `done`, and the result would show any corruption.

// File: rtl/asl_pkg.sv
package asl_pkg;
    localparam int ASL_DW  = 32;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DWALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SHIFT  = 2'b01,
        ST_FINISH = 2'b10
    } state_e;

    function automatic int unsigned top_idx(size_e s);
        unique case (s)
            SZ_BYTE: top_idx = BYTE_W - 1;
            SZ_WORD: top_idx = WORD_W - 1;
            default: top_idx = ASL_DW - 1;
        endcase
    endfunction

    function automatic logic [ASL_DW-1:0] width_mask(size_e s);
        unique case (s)
            SZ_BYTE: width_mask = ASL_DW'({BYTE_W{1'b1}});
            SZ_WORD: width_mask = ASL_DW'({WORD_W{1'b1}});
            default: width_mask = {ASL_DW{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/asl_count_sel.sv
module asl_count_sel #(
    parameter int CNT_W = 5,
    parameter int REG_W = 32
) (
    input  logic             from_reg,
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [REG_W-1:0] reg_cnt,
    output logic [CNT_W-1:0] amount
);
    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_cnt[REG_W-1:CNT_W];

    assign amount = from_reg ? reg_cnt[CNT_W-1:0] : imm_cnt;
endmodule

// File: rtl/asl_step.sv
module asl_step
    import asl_pkg::*;
(
    input  logic [ASL_DW-1:0] cur_val,
    input  size_e             width,
    output logic [ASL_DW-1:0] next_val,
    output logic              out_bit,
    output logic              sign_flip
);
    int unsigned top;

    always_comb begin
        top       = top_idx(width);
        out_bit   = cur_val[top];
        sign_flip = cur_val[top] ^ cur_val[top-1];
        next_val  = {cur_val[ASL_DW-2:0], 1'b0} & width_mask(width);
    end
endmodule

// File: rtl/asl_flags.sv
module asl_flags
    import asl_pkg::*;
(
    input  logic [ASL_DW-1:0] value,
    input  size_e             width,
    output logic              neg,
    output logic              zero
);
    always_comb begin
        neg  = value[top_idx(width)];
        zero = ((value & width_mask(width)) == '0);
    end
endmodule

// File: rtl/asl_iter_unit.sv
module asl_iter_unit
    import asl_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ASL_DW-1:0] operand,
    input  logic [1:0]        size_sel,
    input  logic              cnt_from_reg,
    input  logic [CNT_W-1:0]  cnt_imm,
    input  logic [REG_W-1:0]  cnt_reg,
    output logic [ASL_DW-1:0] result,
    output logic              done,
    output logic              busy,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_z
);
    state_e            st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_sel;
    logic [ASL_DW-1:0] work_q, op_masked, step_next;
    size_e             size_q, size_in;
    logic              v_run_q;
    logic [ASL_DW-1:0] res_q;
    logic              c_q, v_q, n_q, z_q;
    logic              step_out, step_flip;
    logic [ASL_DW-1:0] flg_src;
    size_e             flg_size;
    logic              flg_n, flg_z;
    logic              accept, last_step;

    assign size_in   = size_e'(size_sel);
    assign op_masked = operand & width_mask(size_in);
    assign accept    = (st_q == ST_IDLE) && start;
    assign last_step = (st_q == ST_SHIFT) && (cnt_q == CNT_W'(1));

    asl_count_sel #(.CNT_W(CNT_W), .REG_W(REG_W)) u_cnt (
        .from_reg (cnt_from_reg),
        .imm_cnt  (cnt_imm),
        .reg_cnt  (cnt_reg),
        .amount   (cnt_sel)
    );

    asl_step u_step (
        .cur_val   (work_q),
        .width     (size_q),
        .next_val  (step_next),
        .out_bit   (step_out),
        .sign_flip (step_flip)
    );

    always_comb begin
        if (st_q == ST_IDLE) begin
            flg_src  = op_masked;
            flg_size = size_in;
        end else begin
            flg_src  = step_next;
            flg_size = size_q;
        end
    end

    asl_flags u_flags (
        .value (flg_src),
        .width (flg_size),
        .neg   (flg_n),
        .zero  (flg_z)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = (cnt_sel == '0) ? ST_FINISH : ST_SHIFT;
            ST_SHIFT:  if (last_step) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            work_q  <= '0;
            size_q  <= SZ_BYTE;
            v_run_q <= 1'b0;
            res_q   <= '0;
            c_q     <= 1'b0;
            v_q     <= 1'b0;
            n_q     <= 1'b0;
            z_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        work_q  <= op_masked;
                        size_q  <= size_in;
                        cnt_q   <= cnt_sel;
                        v_run_q <= 1'b0;
                        if (cnt_sel == '0) begin
                            res_q <= op_masked;
                            v_q   <= 1'b0;
                            n_q   <= flg_n;
                            z_q   <= flg_z;
                        end
                    end
                end
                ST_SHIFT: begin
                    work_q  <= step_next;
                    cnt_q   <= cnt_q - 1'b1;
                    v_run_q <= v_run_q | step_flip;
                    if (last_step) begin
                        res_q <= step_next;
                        c_q   <= step_out;
                        v_q   <= v_run_q | step_flip;
                        n_q   <= flg_n;
                        z_q   <= flg_z;
                    end
                end
                default: ;
            endcase
        end
    end

    assign result = res_q;
    assign done   = (st_q == ST_FINISH);
    assign busy   = (st_q != ST_IDLE);
    assign flag_c = c_q;
    assign flag_v = v_q;
    assign flag_n = n_q;
    assign flag_z = z_q;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_one_step_per_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && cnt_q > CNT_W'(1)) |=> (st_q == ST_SHIFT && cnt_q == $past(cnt_q) - 1'b1));

    assert_v_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && v_run_q) |=> v_run_q);

    assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && size_q == SZ_BYTE) |-> (result[ASL_DW-1:BYTE_W] == '0));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(size_q));

    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cnt_sel == '0) |=> (done && $stable(flag_c) && !flag_v));
endmodule

// File: tb/asl_iter_unit_tb.sv
module asl_iter_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size_sel = '0;
    logic        cnt_from_reg = 1'b0;
    logic [4:0]  cnt_imm = '0;
    logic [31:0] cnt_reg = '0;
    logic [31:0] result;
    logic        done, busy, flag_c, flag_v, flag_n, flag_z;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_c = 1'b0;
    logic finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic c, v, n, z;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    asl_iter_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .size_sel(size_sel), .cnt_from_reg(cnt_from_reg), .cnt_imm(cnt_imm),
        .cnt_reg(cnt_reg), .result(result), .done(done), .busy(busy),
        .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
    );

    function automatic exp_t model(logic [31:0] op, logic [1:0] sz, int amt, logic prev_c, string req);
        exp_t e;
        int w;
        logic [31:0] m;
        logic [31:0] val;
        logic msb;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        val = op & m;
        e.c = prev_c;
        e.v = 1'b0;
        for (int i = 0; i < amt; i++) begin
            msb = val[w-1];
            e.c = msb;
            val = (val << 1) & m;
            if (val[w-1] != msb) e.v = 1'b1;
        end
        e.res = val;
        e.n = val[w-1];
        e.z = (val == 0);
        e.req = req;
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] got, logic [31:0] want);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, want);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(result == e.res, e.req, "result", result, e.res);
                check({flag_c, flag_v, flag_n, flag_z} == {e.c, e.v, e.n, e.z}, e.req,
                      "flags CVNZ", {28'd0, flag_c, flag_v, flag_n, flag_z},
                      {28'd0, e.c, e.v, e.n, e.z});
            end
        end
    end

    // driver
    task automatic run_op(logic [31:0] op, logic [1:0] sz, logic from_reg, logic [4:0] imm,
                          logic [31:0] rcnt, string req, bit inject);
        int amt;
        int cyc;
        exp_t e;
        amt = from_reg ? int'(rcnt[4:0]) : int'(imm);
        e = model(op, sz, amt, exp_c, req);
        exp_c = e.c;
        sb_q.push_back(e);
        @(negedge clk);
        operand = op; size_sel = sz; cnt_from_reg = from_reg; cnt_imm = imm; cnt_reg = rcnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                operand = 32'hFFFF_FFFF; cnt_from_reg = 1'b0; cnt_imm = 5'd0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(cyc == amt, "R9", "cycles to done", cyc, amt);
        @(negedge clk);
        check(!done, "R9", "done width", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({busy, done, flag_c, flag_v, flag_n, flag_z} == 6'd0, "R11", "flags/busy in reset",
              {26'd0, busy, done, flag_c, flag_v, flag_n, flag_z}, 32'd0);
        check(result == 32'd0, "R11", "result in reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R11", "busy after reset", {31'd0, busy}, 32'd0);

        run_op(32'h0000_0040, 2'b00, 1'b0, 5'd1, 32'd0, "R1", 1'b0);           // into sign
        run_op(32'h0000_0040, 2'b00, 1'b0, 5'd2, 32'd0, "R6", 1'b0);           // sign out and back
        run_op(32'h0000_0011, 2'b00, 1'b0, 5'd2, 32'd0, "R7", 1'b0);           // clean shift
        run_op(32'h0000_1234, 2'b01, 1'b0, 5'd4, 32'd0, "R1", 1'b0);
        run_op(32'h0000_C001, 2'b01, 1'b0, 5'd1, 32'd0, "R2", 1'b0);           // carry from bit 15
        run_op(32'h8000_0001, 2'b10, 1'b0, 5'd1, 32'd0, "R2", 1'b0);
        run_op(32'h4000_0000, 2'b10, 1'b0, 5'd2, 32'd0, "R6", 1'b0);
        run_op(32'h0000_0003, 2'b10, 1'b1, 5'd9, 32'h0000_0025, "R4", 1'b0);   // low5 = 5
        run_op(32'h0000_8000, 2'b10, 1'b1, 5'd9, 32'h0000_0020, "R4", 1'b0);   // low5 = 0
        run_op(32'h0000_00F0, 2'b00, 1'b0, 5'd0, 32'd0, "R3", 1'b0);
        run_op(32'hABCD_EF01, 2'b00, 1'b0, 5'd3, 32'd0, "R5", 1'b0);           // upper ignored
        run_op(32'hABCD_EF00, 2'b01, 1'b0, 5'd0, 32'd0, "R5", 1'b0);
        run_op(32'h0000_0001, 2'b11, 1'b0, 5'd31, 32'd0, "R5", 1'b0);          // 11 = 32-bit
        run_op(32'h0000_0080, 2'b00, 1'b0, 5'd1, 32'd0, "R8", 1'b0);           // zero result
        run_op(32'h0000_0007, 2'b01, 1'b0, 5'd12, 32'd0, "R10", 1'b1);         // start while busy
        run_op(32'h0000_0003, 2'b00, 1'b0, 5'd0, 32'd0, "R3", 1'b0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R10", "pending items", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule